// File: doc/BRIEF.md
# Network Controller Interrupt Status Word

This block holds the 16-bit status word that a processor reads to learn what a network controller's command unit and receive unit are doing and which of their events still wait for service. The upper byte holds eight sticky event flags. Strobes from the DMA engines, the receive path, the management data interface and the command register set these flags. Software clears any flag by writing a 1 to its position. A write of 0 leaves a flag as it is.

Two of the flags come from watching state rather than from strobes. The command-unit-not-active flag follows the command unit state input, and a mode input selects its style: it can fire whenever the unit drops out of an active queue state, or only when the unit arrives in Idle. The receive-not-ready flag fires when the receive unit's ready level falls. Next to the flags, a 2-bit read-only field shows the current command unit state as it is now. One interrupt output is the OR of the pending flags. The management-data flag counts toward that output only while its enable input is high.

Top module: `nic_irq_status_word`

## Requirements
- R1: While reset is active and right after it is released, the read word is 0000h and the interrupt output is low.
- R2: Each event strobe sets its flag at the next rising clock edge. The flag positions are 15 command executed, 14 frame received, 13 command unit not active, 12 receive not ready, 11 management data done, 10 software interrupt, 9 early receive and 8 flow control pause.
- R3: A write with a 1 at a flag position clears that flag at the next edge. A write with a 0 at a flag position leaves the flag unchanged.
- R4: When a set and a write-1-clear reach the same flag in the same cycle, the flag ends up set.
- R5: The command-executed flag sets only when the command-done strobe and the interrupt-request qualifier are high in the same cycle.
- R6: With the mode input at 0, bit 13 sets when the command unit state goes from an active code (10 or 11) to 00 or 01.
- R7: With the mode input at 1, bit 13 sets only when the state changes from a non-00 code to 00. A move from an active code to 01 leaves it clear.
- R8: Bit 12 sets when the receive-ready level goes from 1 to 0. It does not set on a rising edge or while the level stays steady.
- R9: Bits 7:6 always show the present command unit state: 00 idle, 01 suspended, 10 low-priority queue active, 11 high-priority queue active.
- R10: Bits 5:0 read as zero. Write data in bits 7:0 has no effect.
- R11: The interrupt output is high when any flag is set. Bit 11 counts only while the management interrupt enable is high.
- R12: A flag that receives neither a set nor a clear keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cu_state_i | input | 2 | Command unit state code |
| cna_mode_i | input | 1 | 0: report leaving active; 1: report entering idle |
| cmd_done_i | input | 1 | Command unit finished a command |
| cmd_irq_req_i | input | 1 | Finished command had its interrupt request bit set |
| frame_rx_i | input | 1 | Frame reception finished |
| ru_ready_i | input | 1 | Receive unit ready level |
| mdi_done_i | input | 1 | Management interface cycle finished |
| mdi_irq_en_i | input | 1 | Management data interrupt enable |
| sw_irq_i | input | 1 | Software interrupt request strobe |
| early_rx_i | input | 1 | Early receive event |
| fc_pause_i | input | 1 | Flow control pause event |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | 16 | Write data; a 1 clears the matching flag |
| rd_data_o | output | 16 | Status word |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong transition memory in the command or receive watchers shows up as bit 13 or bit 12 being set, or not being set, one edge after the state change that caused it. The bench therefore compares the whole word at every cycle. A bad clear-versus-set priority shows as a lost flag on the edge where both happen, so the bench drives that collision on purpose. The bench also drives random strobes, writes and state codes against its own model, so a flag that fails to hold or clear shows up within one cycle of the event that disturbed it.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

   typedef enum logic [1:0] {
      CU_IDLE = 2'b00,
      CU_SUSP = 2'b01,
      CU_LPQ  = 2'b10,
      CU_HPQ  = 2'b11
   } cu_state_e;

   typedef enum logic {
      CNA_LEAVE_ACTIVE = 1'b0,
      CNA_ENTER_IDLE   = 1'b1
   } cna_mode_e;

   // positions inside the flag byte (word bit = FLAG_LO + index)
   localparam int FL_CX  = 7;
   localparam int FL_FR  = 6;
   localparam int FL_CNA = 5;
   localparam int FL_RNR = 4;
   localparam int FL_MDI = 3;
   localparam int FL_SWI = 2;
   localparam int FL_ER  = 1;
   localparam int FL_FCP = 0;

   localparam int NUM_FLAGS = 8;

endpackage

// File: rtl/nic_cu_watch.sv
module nic_cu_watch #(
   parameter int ST_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ST_W-1:0] state_i,
   input  logic            mode_i,
   output logic            cna_o
);
   import nic_irq_pkg::*;

   localparam int ACT_BIT = ST_W - 1;

   generate
      if (ST_W != 2) begin : g_bad_width
         $error("nic_cu_watch: state encoding needs exactly two bits");
      end
   endgenerate

   logic [ST_W-1:0] prev_q;
   logic            left_active;
   logic            reached_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= CU_IDLE;
      else        prev_q <= state_i;
   end

   always_comb begin
      left_active  = prev_q[ACT_BIT] & ~state_i[ACT_BIT];
      reached_idle = (state_i == CU_IDLE) && (prev_q != CU_IDLE);
      if (mode_i == CNA_ENTER_IDLE) cna_o = reached_idle;
      else                          cna_o = left_active;
   end

endmodule

// File: rtl/nic_fall_detect.sv
module nic_fall_detect #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] fall_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("nic_fall_detect: width must be positive");
      end
   endgenerate

   logic [W-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_i;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign fall_o[i] = lvl_q[i] & ~lvl_i[i];
      end
   endgenerate

endmodule

// File: rtl/nic_sticky_bank.sv
module nic_sticky_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("nic_sticky_bank: needs at least one flag");
      end
   endgenerate

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
         end

         assign q_o[i] = q;

         // R4 / R2: a set always lands, even against a clear
         p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);

         // R3: a clear without a set empties the flag
         p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);

         // R12: untouched flags hold
         p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
      end
   endgenerate

endmodule

// File: rtl/nic_irq_status_word.sv
module nic_irq_status_word #(
   parameter int WORD_W = 16,
   parameter int FLAG_N = 8,
   parameter int ST_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ST_W-1:0]   cu_state_i,
   input  logic              cna_mode_i,
   input  logic              cmd_done_i,
   input  logic              cmd_irq_req_i,
   input  logic              frame_rx_i,
   input  logic              ru_ready_i,
   input  logic              mdi_done_i,
   input  logic              mdi_irq_en_i,
   input  logic              sw_irq_i,
   input  logic              early_rx_i,
   input  logic              fc_pause_i,
   input  logic              wr_en_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              irq_o
);
   import nic_irq_pkg::*;

   localparam int FLAG_LO = WORD_W - FLAG_N;
   localparam int PAD_W   = FLAG_LO - ST_W;

   generate
      if (FLAG_N != NUM_FLAGS) begin : g_bad_flags
         $error("nic_irq_status_word: flag count must match the event set");
      end
      if (PAD_W < 0) begin : g_bad_word
         $error("nic_irq_status_word: word too narrow for flags and state");
      end
   endgenerate

   logic [FLAG_N-1:0] set_vec;
   logic [FLAG_N-1:0] clr_vec;
   logic [FLAG_N-1:0] flags;
   logic [FLAG_N-1:0] irq_mask;
   logic              cna_ev;
   logic              rnr_ev;

   nic_cu_watch #(.ST_W(ST_W)) u_cu (
      .clk    (clk),
      .rst_n  (rst_n),
      .state_i(cu_state_i),
      .mode_i (cna_mode_i),
      .cna_o  (cna_ev)
   );

   nic_fall_detect #(.W(1)) u_ru (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (ru_ready_i),
      .fall_o(rnr_ev)
   );

   always_comb begin
      set_vec         = '0;
      set_vec[FL_CX]  = cmd_done_i & cmd_irq_req_i;
      set_vec[FL_FR]  = frame_rx_i;
      set_vec[FL_CNA] = cna_ev;
      set_vec[FL_RNR] = rnr_ev;
      set_vec[FL_MDI] = mdi_done_i;
      set_vec[FL_SWI] = sw_irq_i;
      set_vec[FL_ER]  = early_rx_i;
      set_vec[FL_FCP] = fc_pause_i;
      clr_vec = wr_en_i ? wr_data_i[WORD_W-1:FLAG_LO] : '0;
   end

   logic unused_wr_low;
   assign unused_wr_low = ^wr_data_i[FLAG_LO-1:0];

   nic_sticky_bank #(.N(FLAG_N)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_vec),
      .clr_i(clr_vec),
      .q_o  (flags)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data_o = {flags, cu_state_i, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign rd_data_o = {flags, cu_state_i};
      end
   endgenerate

   always_comb begin
      irq_mask         = '1;
      irq_mask[FL_MDI] = mdi_irq_en_i;
      irq_o            = |(flags & irq_mask);
   end

   // R11: any ungated flag drives the interrupt
   p_flag_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_data_o[WORD_W-1:FLAG_LO+FL_MDI+1]) |-> irq_o);

   // R7: in idle-only mode a non-idle state never raises bit 13
   p_idle_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cna_mode_i && (cu_state_i != CU_IDLE) && !rd_data_o[FLAG_LO+FL_CNA])
      |=> !rd_data_o[FLAG_LO+FL_CNA]);

   // R5: a finished command without its request bit leaves bit 15 clear
   p_cmd_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_irq_req_i && !rd_data_o[FLAG_LO+FL_CX]) |=> !rd_data_o[FLAG_LO+FL_CX]);

endmodule

// File: tb/sim_nic_irq_status_word.sv
module sim_nic_irq_status_word;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic [1:0]  cu;
   logic        mode, cdone, creq, frx, rrdy, mdi, mdien, swi, erx, fcp, wen;
   logic [15:0] wdat;
   logic [15:0] rd;
   logic        irq;

   nic_irq_status_word u0 (
      .clk(clk), .rst_n(rst_n), .cu_state_i(cu), .cna_mode_i(mode),
      .cmd_done_i(cdone), .cmd_irq_req_i(creq), .frame_rx_i(frx),
      .ru_ready_i(rrdy), .mdi_done_i(mdi), .mdi_irq_en_i(mdien),
      .sw_irq_i(swi), .early_rx_i(erx), .fc_pause_i(fcp),
      .wr_en_i(wen), .wr_data_i(wdat), .rd_data_o(rd), .irq_o(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] m_flags;
   logic [1:0] m_cu;
   logic       m_ru;

   function automatic logic [7:0] f_set(logic [1:0] pcu, logic pru);
      logic [7:0] s;
      s[7] = cdone & creq;
      s[6] = frx;
      s[5] = mode ? ((cu == 2'b00) && (pcu != 2'b00)) : (pcu[1] && !cu[1]);
      s[4] = pru && !rrdy;
      s[3] = mdi;
      s[2] = swi;
      s[1] = erx;
      s[0] = fcp;
      return s;
   endfunction

   function automatic logic [7:0] f_next(logic [7:0] f, logic [1:0] pcu, logic pru);
      logic [7:0] clr;
      clr = wen ? wdat[15:8] : 8'h00;
      return (f & ~clr) | f_set(pcu, pru);
   endfunction

   function automatic logic f_irq(logic [7:0] f, logic en);
      return |(f & {4'hF, en, 3'h7});
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      cdone = 0; creq = 0; frx = 0; mdi = 0; swi = 0; erx = 0; fcp = 0;
      wen = 0; wdat = 16'h0000;
   endtask

   task automatic step(string tag);
      logic [7:0] nxt;
      nxt = f_next(m_flags, m_cu, m_ru);
      @(posedge clk);
      m_flags = nxt;
      m_cu = cu;
      m_ru = rrdy;
      @(negedge clk);
      chk(tag, rd, {m_flags, cu, 6'b000000});
      chk(tag, {15'd0, irq}, {15'd0, f_irq(m_flags, mdien)});
      idle_inputs();
   endtask

   task automatic clear_all();
      wen = 1; wdat = 16'hFF00;
      step("R3");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R12 watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; cu = 2'b00; mode = 0; rrdy = 0; mdien = 0;
      idle_inputs();
      m_flags = 8'h00; m_cu = 2'b00; m_ru = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", rd, 16'h0000);
      chk("R1", {15'd0, irq}, 16'h0000);
      rst_n = 1;
      @(negedge clk);
      chk("R1", rd, 16'h0000);

      // R2: each strobe individually
      erx = 1; step("R2");
      chk("R2", rd, 16'h0200);
      fcp = 1; step("R2");
      swi = 1; step("R2");
      frx = 1; step("R2");
      chk("R11", {15'd0, irq}, 16'h0001);
      // R3: write 0 keeps, write 1 clears
      wen = 1; wdat = 16'h0000; step("R3");
      chk("R3", rd, 16'h4700);
      wen = 1; wdat = 16'h0200; step("R3");
      chk("R3", rd, 16'h4500);
      // R4: set collides with clear
      frx = 1; wen = 1; wdat = 16'h4000; step("R4");
      chk("R4", rd[15:8], 8'h45);
      clear_all();
      // R5: qualifier
      cdone = 1; creq = 0; step("R5");
      chk("R5", rd[15:8], 8'h00);
      cdone = 1; creq = 1; step("R5");
      chk("R5", rd[15:8], 8'h80);
      clear_all();
      // R6: leave-active mode
      mode = 0;
      cu = 2'b10; step("R6");
      cu = 2'b01; step("R6");
      chk("R6", rd[15:8], 8'h20);
      clear_all();
      cu = 2'b11; step("R6");
      cu = 2'b00; step("R6");
      chk("R6", rd[15:8], 8'h20);
      clear_all();
      // R7: idle-only mode
      mode = 1;
      cu = 2'b10; step("R7");
      cu = 2'b01; step("R7");
      chk("R7", rd[15:8], 8'h00);
      cu = 2'b00; step("R7");
      chk("R7", rd[15:8], 8'h20);
      clear_all();
      // R8: receive ready falling
      rrdy = 1; step("R8");
      chk("R8", rd[15:8], 8'h00);
      rrdy = 0; step("R8");
      chk("R8", rd[15:8], 8'h10);
      step("R8");
      clear_all();
      // R9: live state field
      for (int s = 0; s < 4; s++) begin
         cu = s[1:0]; step("R9");
         chk("R9", {14'd0, rd[7:6]}, {14'd0, s[1:0]});
      end
      mode = 0; cu = 2'b00; step("R9");
      clear_all();
      // R10: low bits
      swi = 1; step("R10");
      wen = 1; wdat = 16'h00FF; step("R10");
      chk("R10", rd, 16'h0400);
      clear_all();
      // R11: management gating
      mdien = 0; mdi = 1; step("R11");
      chk("R11", {15'd0, irq}, 16'h0000);
      chk("R11", rd[15:8], 8'h08);
      mdien = 1; step("R11");
      chk("R11", {15'd0, irq}, 16'h0001);
      clear_all();

      // R12: random mix
      for (int n = 0; n < 3000; n++) begin
         cdone = ($urandom % 8) == 0;
         creq  = $urandom % 2;
         frx   = ($urandom % 8) == 0;
         mdi   = ($urandom % 8) == 0;
         swi   = ($urandom % 8) == 0;
         erx   = ($urandom % 8) == 0;
         fcp   = ($urandom % 8) == 0;
         wen   = ($urandom % 4) == 0;
         wdat  = 16'($urandom);
         if (($urandom % 4) == 0) cu = 2'($urandom);
         if (($urandom % 4) == 0) rrdy = ~rrdy;
         if (($urandom % 32) == 0) mode = ~mode;
         if (($urandom % 16) == 0) mdien = ~mdien;
         step("R12");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule